// File: doc/BRIEF.md
# Synthesizer Programming Register Loader

This block is the write side of a two-wire serial slave that programs a frequency synthesizer. It watches SCL and SDA, which have already been brought into the system clock domain, and finds START and STOP conditions. It matches the first byte of each transaction against a module address, two bits of which come from a strap input. It then routes the data bytes that follow into three shadow registers: a 15-bit divide ratio, a 7-bit control word and an 8-bit port-drive word.

The first data byte after the address chooses the entry point. A clear MSB starts the frequency path, which expects the high divider byte and then the low divider byte. A set MSB starts at the control byte. From either entry point the byte pointer steps forward one byte at a time: low divider byte, then control byte, then ports byte. All four bytes can therefore be written in one transaction, or only a subset of them.

The divide ratio updates as a single word when its low byte completes. A half-written divider is never visible at the outputs.

Top module: `synth_prog_loader`

## Requirements
- R1: The address byte is sent MSB first as 1,1,0,0,0, then strap_i[1], strap_i[0], then the R/W bit (0 = write). On a match with R/W = 0, sda_pull_o is 1 (SDA pulled low) while SCL is high on the 9th clock.
- R2: An address byte that does not match, or that has R/W = 1, gets no acknowledge. Every byte after it in the same transaction gets no acknowledge and changes no output.
- R3: A first data byte whose MSB is 0 stores bits 6..0 as divider bits 14..8. div_word_o changes only when the next byte's 8th SCL rise is sampled, and then becomes {stored bits, that byte}. It never changes after the high byte alone.
- R4: A first data byte whose MSB is 1 is the control byte. On its 8th SCL rise the outputs load as follows: cp_hi_o from bit 6, test_mode_o from bits 5..3, ref_ratio_o from bits 2..1, tune_off_o from bit 0.
- R5: The byte after a control byte is the ports byte. port_drv_o takes all 8 bits on that byte's 8th SCL rise, and a 1 turns the matching port on.
- R6: After the low divider byte, the next byte loads the control outputs whatever its MSB is, and the byte after that loads the ports. A full program is address, high divider, low divider, control, ports in one transaction.
- R7: Data bytes after the ports byte are acknowledged and change no output.
- R8: Every data byte accepted after a matching address is acknowledged on its 9th clock, and sda_pull_o changes only on an SCL fall, a START or a STOP.
- R9: A START in mid-transaction abandons a pending high divider byte and a partly shifted byte. The divider keeps its old value, and the next byte is treated as a new address.
- R10: After a STOP, bytes clocked without a new START get no acknowledge and change no output.
- R11: After reset, div_word_o = 0, cp_hi_o = 0, test_mode_o = 3'b001, ref_ratio_o = 0, tune_off_o = 0, port_drv_o = 0 and sda_pull_o = 0.
- R12: The register outputs change only one clock after an SCL rising edge is sampled, and a single byte never changes the divider and the control/ports outputs together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock, already synchronised |
| sda_i | input | 1 | Serial data line as seen on the bus, already synchronised |
| strap_i | input | 2 | Board-strapped low address bits |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| div_word_o | output | 15 | Programmed divide ratio |
| cp_hi_o | output | 1 | Charge-pump current select, 1 = high |
| test_mode_o | output | 3 | Test mode bits, 001 = normal |
| ref_ratio_o | output | 2 | Reference divider ratio select |
| tune_off_o | output | 1 | 1 = tuning output disabled |
| port_drv_o | output | 8 | Port drive bits, 1 = on |

## Verification
The bench targets these corner cases:
- A transaction that stops after the high divider byte. A design that commits per byte would show a half-updated ratio here.
- A repeated START after the high byte, or in the middle of the low byte. A design that keeps stale staging would later load a divider from mixed transactions.
- Addresses with a wrong strap value or with R/W set. A loose decoder would acknowledge these or write registers from them.
- Bytes past the ports byte, and bytes clocked after a STOP. A pointer that wraps, or a receiver that is not idled, would overwrite registers there.

Random transactions with random entry points and lengths are checked byte by byte against a bench model of the pointer.

// File: rtl/spl_pkg.sv
package spl_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_SKIP} phase_t;
   typedef enum logic [2:0] {SL_FIRST, SL_DLO, SL_CTL, SL_PRT, SL_DONE} slot_t;
   localparam int CTRL_W = 7;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 7'b0_001_00_0;
endpackage

// File: rtl/spl_line_events.sv
module spl_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      start_o = scl_i && scl_q && sda_q && !sda_i;
      stop_o  = scl_i && scl_q && !sda_q && sda_i;
      rise_o  = scl_i && !scl_q;
      fall_o  = !scl_i && scl_q;
   end
endmodule

// File: rtl/spl_byte_rx.sv
module spl_byte_rx
   import spl_pkg::*;
#(
   parameter int STRAP_W = 2,
   parameter logic [6-STRAP_W:0] ADDR_FIXED = 5'b11000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               rise_i,
   input  logic               fall_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               data_vld_o,
   output logic               addr_hit_o,
   output logic [7:0]         data_o,
   output logic               pull_o
);
   localparam int CNT_W = 4;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);
   localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(8);
   localparam logic [CNT_W-1:0] ACK_HOLD = CNT_W'(9);

   phase_t           phase;
   logic [CNT_W-1:0] cnt;
   logic [6:0]       shreg;
   logic             ack_want;
   logic             pull_q;
   logic [7:0]       byte_now;
   logic             byte_end;
   logic             addr_ok;

   assign byte_now = {shreg, sda_i};
   assign byte_end = rise_i && (cnt == LAST_BIT) && (phase != PH_IDLE);
   assign addr_ok  = (byte_now[7:1] == {ADDR_FIXED, strap_i}) && !byte_now[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         ack_want <= 1'b0;
         pull_q   <= 1'b0;
      end else if (start_i) begin
         phase    <= PH_ADDR;
         cnt      <= '0;
         ack_want <= 1'b0;
         pull_q   <= 1'b0;
      end else if (stop_i) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         ack_want <= 1'b0;
         pull_q   <= 1'b0;
      end else if (phase != PH_IDLE) begin
         if (cnt <= LAST_BIT) begin
            if (rise_i) begin
               shreg <= byte_now[6:0];
               cnt   <= cnt + 1'b1;
               if (cnt == LAST_BIT) begin
                  ack_want <= (phase == PH_ADDR) ? addr_ok : (phase == PH_DATA);
                  if (phase == PH_ADDR) phase <= addr_ok ? PH_DATA : PH_SKIP;
               end
            end
         end else if (cnt == ACK_WAIT) begin
            if (fall_i)      pull_q <= ack_want;
            else if (rise_i) cnt    <= ACK_HOLD;
         end else if (fall_i) begin
            pull_q <= 1'b0;
            cnt    <= '0;
         end
      end
   end

   assign data_vld_o = byte_end && (phase == PH_DATA);
   assign addr_hit_o = byte_end && (phase == PH_ADDR) && addr_ok;
   assign data_o     = byte_now;
   assign pull_o     = pull_q;
endmodule

// File: rtl/spl_reg_bank.sv
module spl_reg_bank
   import spl_pkg::*;
#(
   parameter int DIV_W  = 15,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              addr_hit_i,
   input  logic              data_vld_i,
   input  logic [7:0]        data_i,
   output logic [DIV_W-1:0]  div_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [PORT_W-1:0] port_o
);
   localparam int HI_W = DIV_W - 8;

   slot_t             slot;
   logic [HI_W-1:0]   div_hi;
   logic [DIV_W-1:0]  div_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [PORT_W-1:0] port_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot   <= SL_DONE;
         div_hi <= '0;
         div_q  <= '0;
         ctrl_q <= CTRL_RESET;
         port_q <= '0;
      end else if (start_i) begin
         slot <= SL_DONE;
      end else if (addr_hit_i) begin
         slot <= SL_FIRST;
      end else if (data_vld_i) begin
         unique case (slot)
            SL_FIRST: begin
               if (data_i[7]) begin
                  ctrl_q <= data_i[CTRL_W-1:0];
                  slot   <= SL_PRT;
               end else begin
                  div_hi <= data_i[HI_W-1:0];
                  slot   <= SL_DLO;
               end
            end
            SL_DLO: begin
               div_q <= {div_hi, data_i};
               slot  <= SL_CTL;
            end
            SL_CTL: begin
               ctrl_q <= data_i[CTRL_W-1:0];
               slot   <= SL_PRT;
            end
            SL_PRT: begin
               port_q <= data_i[PORT_W-1:0];
               slot   <= SL_DONE;
            end
            default: slot <= SL_DONE;
         endcase
      end
   end

   assign div_o  = div_q;
   assign ctrl_o = ctrl_q;
   assign port_o = port_q;
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
   import spl_pkg::*;
#(
   parameter int DIV_W   = 15,
   parameter int PORT_W  = 8,
   parameter int STRAP_W = 2,
   parameter logic [6-STRAP_W:0] ADDR_FIXED = 5'b11000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_pull_o,
   output logic [DIV_W-1:0]   div_word_o,
   output logic               cp_hi_o,
   output logic [2:0]         test_mode_o,
   output logic [1:0]         ref_ratio_o,
   output logic               tune_off_o,
   output logic [PORT_W-1:0]  port_drv_o
);
   generate
      if (DIV_W < 9 || DIV_W > 15) begin : g_bad_div
         $error("DIV_W must lie in 9..15");
      end
      if (PORT_W < 1 || PORT_W > 8) begin : g_bad_port
         $error("PORT_W must lie in 1..8");
      end
      if (STRAP_W < 1 || STRAP_W > 3) begin : g_bad_strap
         $error("STRAP_W must lie in 1..3");
      end
   endgenerate

   logic start_w, stop_w, rise_w, fall_w;
   logic data_vld_w, addr_hit_w;
   logic [7:0] data_w;
   logic [CTRL_W-1:0] ctrl_w;

   spl_line_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(start_w), .stop_o(stop_w), .rise_o(rise_w), .fall_o(fall_w)
   );

   spl_byte_rx #(.STRAP_W(STRAP_W), .ADDR_FIXED(ADDR_FIXED)) u_rx (
      .clk(clk), .rst_n(rst_n), .start_i(start_w), .stop_i(stop_w),
      .rise_i(rise_w), .fall_i(fall_w), .sda_i(sda_i), .strap_i(strap_i),
      .data_vld_o(data_vld_w), .addr_hit_o(addr_hit_w), .data_o(data_w),
      .pull_o(sda_pull_o)
   );

   spl_reg_bank #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .start_i(start_w), .addr_hit_i(addr_hit_w),
      .data_vld_i(data_vld_w), .data_i(data_w),
      .div_o(div_word_o), .ctrl_o(ctrl_w), .port_o(port_drv_o)
   );

   assign cp_hi_o     = ctrl_w[6];
   assign test_mode_o = ctrl_w[5:3];
   assign ref_ratio_o = ctrl_w[2:1];
   assign tune_off_o  = ctrl_w[0];
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
   parameter int DIV_W  = 15,
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_i,
   input logic              sda_pull_o,
   input logic [DIV_W-1:0]  div_word_o,
   input logic              cp_hi_o,
   input logic [2:0]        test_mode_o,
   input logic [1:0]        ref_ratio_o,
   input logic              tune_off_o,
   input logic [PORT_W-1:0] port_drv_o
);
   logic [6:0] cfg;
   assign cfg = {cp_hi_o, test_mode_o, ref_ratio_o, tune_off_o};

   // R12: divider moves only after a sampled SCL rise
   p_div_on_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_word_o) |-> ($past(scl_i) && !$past(scl_i, 2)));

   // R12: control and ports move only after a sampled SCL rise
   p_cfg_on_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cfg) || !$stable(port_drv_o)) |-> ($past(scl_i) && !$past(scl_i, 2)));

   // R6: one byte commits into one register only
   p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_word_o) |-> ($stable(cfg) && $stable(port_drv_o)));

   p_ctl_port_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg) |-> $stable(port_drv_o));

   // R8: acknowledge drive changes only on SCL fall, START or STOP
   p_ack_edges_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |->
         ((!$past(scl_i) && $past(scl_i, 2)) ||
          ($past(scl_i) && $past(scl_i, 2) && ($past(sda_i) != $past(sda_i, 2)))));
endmodule

bind synth_prog_loader spl_checker #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_spl_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .sda_pull_o(sda_pull_o), .div_word_o(div_word_o), .cp_hi_o(cp_hi_o),
   .test_mode_o(test_mode_o), .ref_ratio_o(ref_ratio_o),
   .tune_off_o(tune_off_o), .port_drv_o(port_drv_o)
);

// File: tb/synth_prog_loader_tb_top.sv
module synth_prog_loader_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [1:0] strap = 2'b10;
   logic sda_line, pull;
   logic [14:0] div;
   logic cp_hi, tune_off;
   logic [2:0] tmode;
   logic [1:0] rratio;
   logic [7:0] ports;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // bench model
   logic [14:0] e_div = '0;
   logic [6:0]  e_ctl = 7'b0_001_00_0;
   logic [7:0]  e_prt = '0;
   logic [6:0]  e_hi = '0;
   int          e_slot = 4;
   bit          e_live = 0;

   always #5 clk = ~clk;

   assign sda_line = m_sda & ~pull;

   synth_prog_loader dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
      .sda_pull_o(pull), .div_word_o(div), .cp_hi_o(cp_hi), .test_mode_o(tmode),
      .ref_ratio_o(rratio), .tune_off_o(tune_off), .port_drv_o(ports)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_outs(input string tag);
      chk({tag, " div"}, 32'(div), 32'(e_div));
      chk({tag, " ctl"}, 32'({cp_hi, tmode, rratio, tune_off}), 32'(e_ctl));
      chk({tag, " prt"}, 32'(ports), 32'(e_prt));
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wt(4);
      m_scl = 1'b1; wt(4);
      m_sda = 1'b0; wt(4);
      m_scl = 1'b0; wt(4);
      e_live = 0; e_slot = 4;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wt(4);
      m_scl = 1'b1; wt(4);
      m_sda = 1'b1; wt(4);
      e_live = 0; e_slot = 4;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wt(4);
         m_scl = 1'b1; wt(4);
         m_scl = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      m_sda = 1'b1; wt(4);
      m_scl = 1'b1; wt(2);
      ack = pull; wt(2);
      m_scl = 1'b0; wt(2);
   endtask

   function automatic logic addr_ok(input logic [7:0] a);
      return a == {5'b11000, strap, 1'b0};
   endfunction

   // model one data byte; returns expected ack
   task automatic mdl_data(input logic [7:0] b, output logic ack);
      ack = e_live;
      if (e_live) begin
         case (e_slot)
            0: if (b[7]) begin e_ctl = b[6:0]; e_slot = 3; end
               else begin e_hi = b[6:0]; e_slot = 1; end
            1: begin e_div = {e_hi, b}; e_slot = 2; end
            2: begin e_ctl = b[6:0]; e_slot = 3; end
            3: begin e_prt = b; e_slot = 4; end
            default: ;
         endcase
      end
   endtask

   task automatic xfer_addr(input logic [7:0] a, input string tag);
      logic ack;
      send_byte(a, ack);
      chk({tag, " addr ack"}, 32'(ack), 32'(addr_ok(a)));
      e_live = addr_ok(a);
      e_slot = 0;
   endtask

   task automatic xfer_data(input logic [7:0] b, input string tag);
      logic ack, eack;
      mdl_data(b, eack);
      send_byte(b, ack);
      chk({tag, " data ack"}, 32'(ack), 32'(eack));
      chk_outs(tag);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
      end
   end

   localparam logic [7:0] ADR = {5'b11000, 2'b10, 1'b0};

   initial begin
      logic ack;
      void'($urandom(32'd20240611));
      wt(5);
      rst_n = 1'b1;
      wt(2);
      // R11 reset state
      chk("R11 pull", 32'(pull), 32'd0);
      chk_outs("R11 reset");

      // R1 R3 R6 R8 full program in one transaction
      bus_start();
      xfer_addr(ADR, "R1");
      xfer_data(8'h2A, "R3 high byte only");
      xfer_data(8'h5C, "R3 low byte");
      xfer_data(8'hC9, "R6 ctl after div");
      xfer_data(8'hA5, "R5 ports");
      xfer_data(8'hFF, "R7 beyond ports");
      xfer_data(8'h00, "R7 beyond ports 2");
      bus_stop();

      // R4 R5 partial from control byte
      bus_start();
      xfer_addr(ADR, "R1 partial");
      xfer_data(8'hBE, "R4 ctl first");
      xfer_data(8'h3C, "R5 ports after ctl");
      bus_stop();

      // R3 high byte then STOP: divider unchanged
      bus_start();
      xfer_addr(ADR, "R3");
      xfer_data(8'h11, "R3 stop after high");
      bus_stop();
      chk_outs("R3 after stop");

      // R9 repeated start after high byte and mid low byte
      bus_start();
      xfer_addr(ADR, "R9");
      xfer_data(8'h7F, "R9 high");
      send_bits(8'hAA, 4);
      bus_start();
      xfer_addr(ADR, "R9 readdress");
      xfer_data(8'h22, "R9 fresh first byte");
      bus_start();
      xfer_addr(ADR, "R9 readdress 2");
      xfer_data(8'h81, "R9 ctl");
      bus_stop();

      // R2 wrong strap, then read direction
      bus_start();
      xfer_addr({5'b11000, 2'b01, 1'b0}, "R2 strap");
      xfer_data(8'h85, "R2 ignored");
      bus_stop();
      bus_start();
      xfer_addr({5'b11000, 2'b10, 1'b1}, "R2 rw");
      xfer_data(8'h85, "R2 rw ignored");
      bus_stop();

      // R10 byte after stop without start
      send_byte(8'h80, ack);
      chk("R10 no ack", 32'(ack), 32'd0);
      chk_outs("R10 no change");

      // random mix
      for (int t = 0; t < 40; t++) begin
         logic [7:0] a;
         int nb;
         bit ctl_first;
         a = ADR;
         if ($urandom % 6 == 0) a = 8'($urandom);
         nb = 1 + int'($urandom % 6);
         ctl_first = 1'($urandom % 2);
         bus_start();
         xfer_addr(a, "R1 rnd");
         for (int k = 0; k < nb; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (k == 0) d[7] = ctl_first;
            xfer_data(d, "R6 rnd");
         end
         if ($urandom % 4 == 0) begin
            send_bits(8'($urandom), 3);
            bus_start();
            chk_outs("R9 rnd abort");
         end
         bus_stop();
      end

      done = 1;
      summary();
   end
endmodule